// File: doc/BRIEF.md
# Streaming Block-Program Sequencer

This block fronts a small on-chip model of a flash array and runs a fast factory-programming session. The host names a start address with a setup command. It then sends only data words. After each program pulse the sequencer moves the word address forward by itself. The host polls a status byte and waits for ready before it sends the next word.

A session covers a single block. It ends in one of two ways: the host sends an end marker, or the address passes the last word of the block. The sequencer then reads back every word it programmed, compares each one with a private shadow copy, and returns to normal read mode. While a session is open, array reads are refused and suspend requests are rejected. Setup is refused when the target block is locked or the program supply is not reported good.

Top module: `flash_stream_prog`

## Requirements
- R1: After reset the status byte is 0x80: ready in bit 7 set, all other bits clear. `rd_busy` is 0, `fail_addr` is 0, and every array word reads as all ones.
- R2: Writing 0x0030 at any address while idle opens a session. The session passes through streaming, then internal verify, then a one-cycle exit, then back to idle. Status bit 0 is set from the cycle after setup until the cycle after exit.
- R3: Each accepted data write drives ready low for exactly `PULSE_CYC` cycles. Any data write that arrives while ready is low does not program anything.
- R4: A data write is any write whose address lies inside the target block. It programs the current word address, not the written address. The cell becomes old AND data. The current address then advances by one.
- R5: Once the last word of the block has been programmed, streaming stops and verify starts with no host action.
- R6: Writing an all-ones word to an address outside the target block while ready ends streaming and starts verify.
- R7: Verify takes one cycle per block word and then one exit cycle. If any programmed word differs from its shadow copy, status bit 4 is set at exit and `fail_addr` takes the lowest such address.
- R8: During a session, writing 0x00B0 to an address outside the block does not pause or change the session and sets status bit 2.
- R9: A read request takes effect one cycle later. During a session it gives `rd_busy`=1 and `rd_data`=0. When idle it gives `rd_busy`=0 and the array word.
- R10: A setup aimed at a locked block sets status bit 1. A setup with `vpp_ok` low sets status bit 3. In both cases the block stays idle.
- R11: Error bits 4, 3, 2 and 1 persist across sessions. They clear only when 0x0050 is written while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write word address |
| wr_data | input | DATA_W | Host write data or command code |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read word address |
| rd_data | output | DATA_W | Read result, one cycle after the request |
| rd_busy | output | 1 | Read refused because a session is open |
| vpp_ok | input | 1 | Program supply is in range |
| blk_lock | input | 2**(ADDR_W-BLK_W) | Per-block lock flags |
| status | output | 8 | Status byte: ready, program error, supply error, suspend refused, lock error, session active |
| fail_addr | output | ADDR_W | Lowest address that failed the last verify |

## Verification
The status byte is combinational from registered state, so it reflects each write edge by the next falling edge. Ready falls right after a data write and returns `PULSE_CYC` edges later. Verify results appear `2**BLK_W`+1 edges after verify starts. Read results appear one edge after the request. The bench's reference model steps once on every rising edge using counters and queues, and the outputs are compared with it on every falling edge. Every result is therefore checked in exactly the cycle it is due, never earlier and never later.

// File: rtl/flash_stream_prog.sv
module flash_stream_prog #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BLK_W     = 4,
  parameter int PULSE_CYC = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_busy,
  input  logic                           vpp_ok,
  input  logic [(1<<(ADDR_W-BLK_W))-1:0] blk_lock,
  output logic [7:0]                     status,
  output logic [ADDR_W-1:0]              fail_addr
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int BLK   = 1 << BLK_W;
  localparam int BN_W  = ADDR_W - BLK_W;
  localparam int CW    = $clog2(PULSE_CYC + 1);
  localparam logic [DATA_W-1:0] CMD_SETUP = DATA_W'(16'h0030);
  localparam logic [DATA_W-1:0] CMD_CLR   = DATA_W'(16'h0050);
  localparam logic [DATA_W-1:0] CMD_SUSP  = DATA_W'(16'h00B0);
  localparam logic [DATA_W-1:0] END_MARK  = '1;

  typedef enum logic [1:0] {S_IDLE, S_PROG, S_VER, S_EXIT} st_t;
  st_t st;

  logic [DATA_W-1:0] mem    [WORDS];
  logic [DATA_W-1:0] shadow [BLK];
  logic [BLK-1:0]    sval;
  logic [ADDR_W-1:0] addr, vaddr;
  logic [BN_W-1:0]   blk;
  logic [CW-1:0]     cnt;
  logic [BLK_W-1:0]  vidx;
  logic              vbad;
  logic              e_prog, e_volt, e_susp, e_lock;

  wire [BLK_W-1:0]  off    = addr[BLK_W-1:0];
  wire              in_blk = wr_addr[ADDR_W-1:BLK_W] == blk;
  wire              active = st != S_IDLE;
  wire              rdy    = (st == S_IDLE) || (st == S_PROG && cnt == '0);
  wire              fire   = st == S_PROG && cnt == CW'(1);
  wire              take   = st == S_PROG && cnt == '0 && wr_en && in_blk;
  wire [ADDR_W-1:0] vptr   = {blk, vidx};
  wire              vmis   = sval[vidx] && (mem[vptr] != shadow[vidx]);

  assign status = {rdy, 2'b00, e_prog, e_volt, e_susp, e_lock, active};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (fire) begin
      mem[addr] <= mem[addr] & shadow[off];
    end
  end

  always_ff @(posedge clk) begin
    if (take) shadow[off] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; addr <= '0; blk <= '0; cnt <= '0; sval <= '0;
      vidx <= '0; vbad <= 1'b0; vaddr <= '0; fail_addr <= '0;
      e_prog <= 1'b0; e_volt <= 1'b0; e_susp <= 1'b0; e_lock <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (wr_en && wr_data == CMD_SETUP) begin
            if (blk_lock[wr_addr[ADDR_W-1:BLK_W]] || !vpp_ok) begin
              if (blk_lock[wr_addr[ADDR_W-1:BLK_W]]) e_lock <= 1'b1;
              if (!vpp_ok) e_volt <= 1'b1;
            end else begin
              st   <= S_PROG;
              addr <= wr_addr;
              blk  <= wr_addr[ADDR_W-1:BLK_W];
              cnt  <= '0;
              sval <= '0;
            end
          end else if (wr_en && wr_data == CMD_CLR) begin
            e_prog <= 1'b0; e_volt <= 1'b0; e_susp <= 1'b0; e_lock <= 1'b0;
          end
        end
        S_PROG: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
              if (off == BLK_W'(BLK - 1)) begin
                st <= S_VER; vidx <= '0; vbad <= 1'b0;
              end else begin
                addr <= addr + 1'b1;
              end
            end
          end else if (take) begin
            sval[off] <= 1'b1;
            cnt       <= CW'(PULSE_CYC);
          end else if (wr_en && wr_data == END_MARK) begin
            st <= S_VER; vidx <= '0; vbad <= 1'b0;
          end
        end
        S_VER: begin
          if (vmis && !vbad) begin
            vbad  <= 1'b1;
            vaddr <= vptr;
          end
          vidx <= vidx + 1'b1;
          if (vidx == BLK_W'(BLK - 1)) st <= S_EXIT;
        end
        default: begin
          if (vbad) begin
            e_prog    <= 1'b1;
            fail_addr <= vaddr;
          end
          st <= S_IDLE;
        end
      endcase
      if (active && wr_en && !in_blk && wr_data == CMD_SUSP) e_susp <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_busy <= 1'b0;
    end else if (rd_en) begin
      rd_busy <= active;
      rd_data <= active ? '0 : mem[rd_addr];
    end else begin
      rd_busy <= 1'b0;
    end
  end

  a_r2_verify_to_exit: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_VER |=> (st == S_VER || st == S_EXIT));
  a_r2_exit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_EXIT |=> (st == S_IDLE && status[7]));
  a_r3_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && cnt > CW'(1)) |=> (st == S_PROG && !status[7] && $stable(addr)));
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && off != BLK_W'(BLK - 1)) |=> addr == $past(addr) + 1'b1);
  a_r5_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PROG |-> addr[ADDR_W-1:BLK_W] == blk);
  a_r9_read_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && active) |=> (rd_busy && rd_data == '0));
  a_r10_supply_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && wr_en && wr_data == CMD_SETUP && !vpp_ok) |=> (st == S_IDLE && status[3]));
endmodule

// File: tb/flash_stream_prog_bench.sv
module flash_stream_prog_bench;
  localparam int AW = 8, DW = 16, BW = 4, PC = 3;
  localparam int NB = 1 << (AW - BW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, vpp_ok = 1'b1;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] blk_lock = '0;
  logic [DW-1:0] rd_data;
  logic rd_busy;
  logic [7:0] status;
  logic [AW-1:0] fail_addr;

  always #4 clk = ~clk;

  flash_stream_prog #(.ADDR_W(AW), .DATA_W(DW), .BLK_W(BW), .PULSE_CYC(PC)) u_flash_stream_prog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_busy(rd_busy),
    .vpp_ok(vpp_ok), .blk_lock(blk_lock), .status(status), .fail_addr(fail_addr));

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // reference model: 0 idle, 1 streaming, 2 verify+exit
  int m_st, m_cnt, m_addr, m_blk, m_tmr, m_fail;
  logic [DW-1:0] m_mem [0:(1<<AW)-1];
  logic [DW-1:0] m_pd, m_rdd;
  logic m_busy, m_prog, m_volt, m_susp, m_lock;
  int q_a[$];
  logic [DW-1:0] q_d[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_addr = 0; m_blk = 0; m_tmr = 0; m_fail = 0;
      for (int i = 0; i < (1<<AW); i++) m_mem[i] = '1;
      m_rdd = '0; m_busy = 0; m_prog = 0; m_volt = 0; m_susp = 0; m_lock = 0;
    end else begin
      if (rd_en) begin
        m_busy = (m_st != 0);
        m_rdd  = (m_st != 0) ? '0 : m_mem[rd_addr];
      end else m_busy = 0;
      if (m_st != 0 && wr_en && (int'(wr_addr) >> BW) != m_blk && wr_data == 16'h00B0) m_susp = 1;
      if (m_st == 0) begin
        if (wr_en && wr_data == 16'h0030) begin
          if (blk_lock[int'(wr_addr) >> BW] || !vpp_ok) begin
            if (blk_lock[int'(wr_addr) >> BW]) m_lock = 1;
            if (!vpp_ok) m_volt = 1;
          end else begin
            m_st = 1; m_addr = wr_addr; m_blk = int'(wr_addr) >> BW; m_cnt = 0;
            q_a.delete(); q_d.delete();
          end
        end else if (wr_en && wr_data == 16'h0050) begin
          m_prog = 0; m_volt = 0; m_susp = 0; m_lock = 0;
        end
      end else if (m_st == 1) begin
        if (m_cnt > 0) begin
          m_cnt--;
          if (m_cnt == 0) begin
            m_mem[m_addr] = m_mem[m_addr] & m_pd;
            q_a.push_back(m_addr); q_d.push_back(m_pd);
            if ((m_addr % (1<<BW)) == (1<<BW) - 1) begin m_st = 2; m_tmr = (1<<BW) + 1; end
            else m_addr++;
          end
        end else if (wr_en && (int'(wr_addr) >> BW) == m_blk) begin
          m_pd = wr_data; m_cnt = PC;
        end else if (wr_en && wr_data == 16'hFFFF) begin
          m_st = 2; m_tmr = (1<<BW) + 1;
        end
      end else begin
        m_tmr--;
        if (m_tmr == 0) begin
          for (int k = 0; k < q_a.size(); k++)
            if (m_mem[q_a[k]] != q_d[k]) begin m_prog = 1; m_fail = q_a[k]; break; end
          m_st = 0;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 status byte", 32'(status),
        32'({(m_st == 0 || (m_st == 1 && m_cnt == 0)), 2'b00, m_prog, m_volt, m_susp, m_lock, m_st != 0}));
    chk("R7 fail_addr", 32'(fail_addr), 32'(m_fail));
    chk("R9 rd_busy", 32'(rd_busy), 32'(m_busy));
    chk("R9 rd_data", 32'(rd_data), 32'(m_rdd));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(int a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(int a);
    @(negedge clk); rd_en = 1; rd_addr = AW'(a);
    @(negedge clk); rd_en = 0;
  endtask
  task automatic wait_ready();
    while (!status[7]) @(negedge clk);
  endtask
  task automatic wait_idle();
    while (status[0]) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", 32'(status), 32'h80);
    chk("R1 reset fail_addr", 32'(fail_addr), 0);
    rd(8'h40);
    chk("R1 erased word", 32'(rd_data), 32'hFFFF);

    vpp_ok = 0; wr(8'h12, 16'h0030); vpp_ok = 1;
    chk("R10 supply reject", 32'(status), 32'h88);
    wr(0, 16'h0050);
    chk("R11 clear after supply", 32'(status), 32'h80);
    blk_lock = NB'(4);
    wr(8'h25, 16'h0030);
    chk("R10 lock reject", 32'(status), 32'h82);
    wr(0, 16'h0050);
    blk_lock = '0;

    wr(8'h12, 16'h0030);
    chk("R2 session open", 32'(status), 32'h81);
    wr(8'h1F, 16'h1234);
    wr(8'h10, 16'h0000);
    wr(8'h80, 16'h00B0);
    chk("R8 suspend flagged", 32'(status[2]), 1);
    chk("R8 session continues", 32'(status[0]), 1);
    rd(8'h40);
    chk("R9 busy read", 32'(rd_busy), 1);
    wait_ready(); wr(8'h10, 16'hA5A5);
    wait_ready(); wr(8'h10, 16'h0F0F);
    wait_ready(); wr(8'h10, 16'h00FF);
    wait_ready(); wr(8'hF0, 16'hFFFF);
    wait_idle();
    chk("R6 marker ends session", 32'(status), 32'h84);
    rd(8'h12);
    chk("R3 busy write ignored", 32'(rd_data), 32'h1234);
    rd(8'h14);
    chk("R4 auto address", 32'(rd_data), 32'h0F0F);

    wr(8'h3C, 16'h0030);
    chk("R11 error persists", 32'(status[2]), 1);
    for (int i = 0; i < 4; i++) begin wait_ready(); wr(8'h30, 16'(16'h1111 * (i + 1))); end
    wait_idle();
    rd(8'h3F);
    chk("R5 block end stops", 32'(rd_data), 32'h4444);

    wr(0, 16'h0050);
    wr(8'h12, 16'h0030);
    wait_ready(); wr(8'h10, 16'h1234);
    wait_ready(); wr(8'h10, 16'hFFFF);
    wait_ready(); wr(8'hF0, 16'hFFFF);
    wait_idle();
    chk("R7 program error", 32'(status), 32'h90);
    chk("R7 failing address", 32'(fail_addr), 32'h13);
    rd(8'h13);
    chk("R4 AND result", 32'(rd_data), 32'hA5A5);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule